// File: doc/BRIEF.md
# PROM Byte-Programming Sequencer

The sequencer writes an inclusive address range of an ultraviolet-erasable PROM, one byte at a time, in the order the device needs. After a start request it turns the programming supply on. The device's active-low output enable stays high while each location is written. For every location the block first puts the address on the bus and then the data byte. It then applies a long positive program pulse, whose length is counted in clock cycles, and holds address and data for one more cycle. Finally it reads the location back through the output enable and compares the result with the byte it wrote.

A byte source supplies one byte per location over a valid/ready interface, in ascending address order. The sequencer raises `byte_ready` only while it waits for the next byte. A transfer takes place on a rising clock edge where `byte_valid` and `byte_ready` are both high. The source may hold `byte_valid` low for any number of cycles and the sequencer simply waits. The byte must stay stable while `byte_valid` is high. A byte of FFh matches an erased cell, so the sequencer takes it and moves on to the next location without programming it.

If a readback differs from the byte written, the run stops and the block reports the failing address. At the end of every run the block turns the supply off, returns every control to its inactive level and pulses `done`.

Top module: `prom_prog_seq`

## Requirements
- R1: A `start` pulse is taken only while the block is idle, meaning `busy` and `done` are both low. Taking it latches `first_addr` and `last_addr`, and `start` has no effect at any other time. If `first_addr > last_addr`, the only response is a `done` pulse one cycle later; `vpp_en` never rises and no byte is taken.
- R2: In the first cycle that `vpp_en` is high, `byte_ready`, `addr_oe`, `dq_oe` and `prog_pulse` are low and `oe_n` is high.
- R3: Whenever `prog_pulse` is high, `vpp_en` is high and `oe_n` is high.
- R4: For each programmed byte, `addr_oe` is high with the same address for at least one cycle before `dq_oe` rises. `dq_oe` is high for at least one cycle before `prog_pulse` rises.
- R5: Each programmed byte receives exactly one `prog_pulse` high interval, lasting exactly PULSE_CYC consecutive cycles.
- R6: `addr_o` and `dq_out` are constant from the cycle before `prog_pulse` rises until the cycle after it falls. In that cycle after the fall, `dq_oe` is still high.
- R7: Bytes are taken one per location, on edges with `byte_valid && byte_ready`, for addresses `first_addr`, `first_addr+1`, … `last_addr`. `byte_ready` is high only while `vpp_en` is high and `addr_oe` is low. A stalled source only delays the run.
- R8: A byte equal to 8'hFF causes no pulse and no address drive, and it leaves its location unchanged.
- R9: After the hold cycle, `dq_oe` is low and `oe_n` is low for exactly READ_CYC cycles. `dq_in` is compared with the written byte in the last of those cycles.
- R10: On a readback mismatch, `error` rises and `err_addr` holds the failing address. No further byte is taken and the run ends. `error` and `err_addr` hold until the next taken `start`, which clears them.
- R11: A run ends with `done` high for exactly one cycle. In that cycle `busy`, `vpp_en`, `addr_oe`, `dq_oe`, `prog_pulse` and `byte_ready` are low and `oe_n` is high.
- R12: During reset, all controls are inactive (`oe_n` high, the others low) and `done`, `error` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (inclusive) |
| byte_valid | input | 1 | Source has a byte |
| byte_data | input | 8 | Byte for the next location |
| byte_ready | output | 1 | Sequencer accepts a byte this cycle |
| dq_in | input | 8 | Data read from the device |
| vpp_en | output | 1 | Programming supply enable |
| oe_n | output | 1 | Device output enable, active low |
| addr_oe | output | 1 | Address bus is driven |
| addr_o | output | AW | Device address (zero when not driven) |
| dq_oe | output | 1 | Data bus is driven by the sequencer |
| dq_out | output | 8 | Data to program (zero when not driven) |
| prog_pulse | output | 1 | Program pulse, active high |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Readback mismatch seen in the last run |
| err_addr | output | AW | Address of the mismatch |

## Verification
The hardest case to reach is a readback mismatch. A correct device model always returns the byte that was programmed, so the ports alone never cause one. The bench device model therefore has a per-address mask of bits that will not program to zero. One run places a fault mid-range on a non-FFh location. The bench then checks that the run stops there, that later locations remain erased and that the error holds until the next run clears it. A second hard case is a `start` pulse that arrives during a run. The bench sends one partway through a partial-range run, with a wider range on the address inputs, and confirms that only the original range was written.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SUPPLY,
    ST_FETCH,
    ST_ADDR,
    ST_DATA,
    ST_PULSE,
    ST_HOLD,
    ST_READ,
    ST_DONE
  } seq_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/prom_cycle_timer.sv
module prom_cycle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R5
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/prom_addr_walker.sv
module prom_addr_walker #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          at_last
);

  logic [AW-1:0] cur_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
    end else if (load) begin
      cur_q  <= first;
      last_q <= last;
    end else if (step) begin
      cur_q  <= cur_q + 1'b1;
    end
  end

  assign cur     = cur_q;
  assign at_last = (cur_q == last_q);

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);

endmodule

// File: rtl/prom_readback_check.sv
module prom_readback_check #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          check,
  input  logic [7:0]    want,
  input  logic [7:0]    got,
  input  logic [AW-1:0] addr,
  output logic          mismatch,
  output logic          err,
  output logic [AW-1:0] err_addr
);

  assign mismatch = (want != got);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err      <= 1'b0;
      err_addr <= '0;
    end else if (check && mismatch) begin
      err      <= 1'b1;
      err_addr <= addr;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear) |=> (err && $stable(err_addr)));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !err);

endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_prog_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PULSE_CYC = 10_000_000,
  parameter int READ_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  input  logic [7:0]    dq_in,
  output logic          vpp_en,
  output logic          oe_n,
  output logic          addr_oe,
  output logic [AW-1:0] addr_o,
  output logic          dq_oe,
  output logic [7:0]    dq_out,
  output logic          prog_pulse,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr
);

  localparam int MAXC = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PULSE_LOAD = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] READ_LOAD  = TW'(READ_CYC - 1);

  seq_state_t state_q, state_d;
  logic [7:0]    byte_q;
  logic          cap;
  logic          wl_load, wl_step, at_last;
  logic [AW-1:0] cur;
  logic          tm_load, tm_zero;
  logic [TW-1:0] tm_val;
  logic          vf_check, vf_clear, mismatch;

  prom_addr_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(wl_load), .first(first_addr),
    .last(last_addr), .step(wl_step), .cur(cur), .at_last(at_last)
  );

  prom_cycle_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .expired(tm_zero)
  );

  prom_readback_check #(.AW(AW)) u_check (
    .clk(clk), .rst_n(rst_n), .clear(vf_clear), .check(vf_check),
    .want(byte_q), .got(dq_in), .addr(cur), .mismatch(mismatch),
    .err(error), .err_addr(err_addr)
  );

  always_comb begin
    state_d  = state_q;
    wl_load  = 1'b0;
    wl_step  = 1'b0;
    tm_load  = 1'b0;
    tm_val   = '0;
    vf_check = 1'b0;
    vf_clear = 1'b0;
    cap      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          vf_clear = 1'b1;
          wl_load  = 1'b1;
          state_d  = (first_addr <= last_addr) ? ST_SUPPLY : ST_DONE;
        end
      end
      ST_SUPPLY: state_d = ST_FETCH;
      ST_FETCH: begin
        if (byte_valid) begin
          cap = 1'b1;
          if (byte_data == ERASED_BYTE) begin
            if (at_last) state_d = ST_DONE;
            else         wl_step = 1'b1;
          end else begin
            state_d = ST_ADDR;
          end
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        tm_load = 1'b1;
        tm_val  = PULSE_LOAD;
        state_d = ST_PULSE;
      end
      ST_PULSE: if (tm_zero) state_d = ST_HOLD;
      ST_HOLD: begin
        tm_load = 1'b1;
        tm_val  = READ_LOAD;
        state_d = ST_READ;
      end
      ST_READ: begin
        if (tm_zero) begin
          vf_check = 1'b1;
          if (mismatch || at_last) begin
            state_d = ST_DONE;
          end else begin
            wl_step = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cap) byte_q <= byte_data;
    end
  end

  assign vpp_en     = state_q inside {ST_SUPPLY, ST_FETCH, ST_ADDR, ST_DATA,
                                      ST_PULSE, ST_HOLD, ST_READ};
  assign byte_ready = (state_q == ST_FETCH);
  assign addr_oe    = state_q inside {ST_ADDR, ST_DATA, ST_PULSE, ST_HOLD, ST_READ};
  assign addr_o     = addr_oe ? cur : '0;
  assign dq_oe      = state_q inside {ST_DATA, ST_PULSE, ST_HOLD};
  assign dq_out     = dq_oe ? byte_q : 8'h00;
  assign prog_pulse = (state_q == ST_PULSE);
  assign oe_n       = (state_q != ST_READ);
  assign done       = (state_q == ST_DONE);
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);

  // R2
  supply_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> (!byte_ready && !addr_oe && !dq_oe && oe_n && !prog_pulse));

  // R3
  pulse_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (vpp_en && oe_n));

  // R4
  data_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_pulse) |-> $past(dq_oe));

  // R4
  addr_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(addr_oe) && $stable(addr_o)));

  // R6
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> ($stable(addr_o) && $stable(dq_out)));

  // R6
  hold_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> (dq_oe && $stable(addr_o) && $stable(dq_out)));

  // R7
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (vpp_en && !addr_oe));

  // R9
  read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!dq_oe && addr_oe && vpp_en));

  // R11
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !vpp_en && oe_n && !addr_oe && !dq_oe && !byte_ready));

endmodule

// File: tb/sim_prom_prog_seq.sv
`timescale 1ns/1ps
module sim_prom_prog_seq;

  localparam int AW    = 4;
  localparam int PULSE = 5;
  localparam int READ  = 2;
  localparam int NLOC  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready, vpp_en, oe_n, addr_oe, dq_oe, prog_pulse, busy, done, error;
  logic [AW-1:0] addr_o, err_addr;
  logic [7:0] dq_out, dq_in;

  always #2.5 clk = ~clk;

  prom_prog_seq #(.AW(AW), .PULSE_CYC(PULSE), .READ_CYC(READ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .dq_in(dq_in), .vpp_en(vpp_en), .oe_n(oe_n),
    .addr_oe(addr_oe), .addr_o(addr_o), .dq_oe(dq_oe), .dq_out(dq_out),
    .prog_pulse(prog_pulse), .busy(busy), .done(done), .error(error),
    .err_addr(err_addr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // device model: cells only go 1 -> 0; stuck mask bits never clear on readback
  logic [7:0] mem   [NLOC];
  logic [7:0] stuck [NLOC];
  always @(posedge clk) if (prog_pulse && vpp_en) mem[addr_o] <= mem[addr_o] & dq_out;
  assign dq_in = (!oe_n && addr_oe) ? (mem[addr_o] | stuck[addr_o]) : 8'h00;

  function automatic logic [7:0] src_byte(int a, int s);
    logic [7:0] v;
    if (a % 5 == 3) return 8'hFF;
    v = 8'((a * 53 + s * 29 + 17) & 255);
    if (v == 8'hFF) v = 8'h0F;
    return v;
  endfunction

  // byte source with stalls
  bit src_on = 0;
  int src_base = 0, seed = 0, idx = 0, stall = 0;
  bit take = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (take) begin idx++; stall = idx % 3; end
      if (!src_on) byte_valid = 1'b0;
      else if (stall > 0) begin byte_valid = 1'b0; stall--; end
      else begin
        byte_valid = 1'b1;
        byte_data  = src_byte(src_base + idx, seed);
      end
      take = byte_valid && byte_ready && rst_n;
    end
  end

  // port monitor
  logic pv_vpp = 0, pv_addr_oe = 0, pv_dq_oe = 0, pv_pulse = 0, pv_oe_n = 1, pv_done = 0;
  logic [AW-1:0] pv_addr = '0, p_addr = '0;
  logic [7:0] p_dat = '0;
  int pw = 0, rw = 0, pulses = 0, vpp_rises = 0;
  bit bad_stab = 0, bad_read = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (vpp_en && !pv_vpp) begin
        vpp_rises++;
        chk(!byte_ready && !addr_oe && !dq_oe && oe_n && !prog_pulse, "R2 supply first",
            {byte_ready, addr_oe, dq_oe, oe_n}, 4'b0001);
      end
      if (dq_oe && !pv_dq_oe)
        chk(pv_addr_oe && pv_addr == addr_o, "R4 address before data", pv_addr_oe, 1);
      if (prog_pulse && !pv_pulse) begin
        pulses++;
        chk(pv_dq_oe && vpp_en && oe_n, "R4/R3 data and supply before pulse",
            {pv_dq_oe, vpp_en, oe_n}, 3'b111);
        pw = 1; p_addr = addr_o; p_dat = dq_out;
      end else if (prog_pulse) pw++;
      if (prog_pulse && (addr_o != p_addr || dq_out != p_dat || !oe_n)) bad_stab = 1;
      if (!prog_pulse && pv_pulse) begin
        chk(pw == PULSE, "R5 pulse width", pw, PULSE);
        chk(!bad_stab && dq_oe && addr_o == p_addr && dq_out == p_dat,
            "R6 stable through hold", bad_stab, 0);
        bad_stab = 0;
      end
      if (!oe_n) begin rw++; if (dq_oe) bad_read = 1; end
      if (oe_n && !pv_oe_n) begin
        chk(rw == READ && !bad_read, "R9 readback window", rw, READ);
        rw = 0; bad_read = 0;
      end
      if (pv_done) chk(!done, "R11 done one cycle", done, 0);
      if (done)
        chk(!busy && !vpp_en && oe_n && !addr_oe && !dq_oe && !prog_pulse && !byte_ready,
            "R11 quiet at done", {busy, vpp_en, oe_n, addr_oe, dq_oe}, 5'b00100);
    end
    pv_vpp = vpp_en; pv_addr_oe = addr_oe; pv_dq_oe = dq_oe; pv_pulse = prog_pulse;
    pv_oe_n = oe_n; pv_done = done; pv_addr = addr_o;
  end

  task automatic run(int f, int l, int s, int fault, bit poke);
    int exp_pulses = 0, exp_taken = 0, stop;
    bit got_done = 0;
    for (int a = 0; a < NLOC; a++) begin mem[a] = 8'hFF; stuck[a] = 8'h00; end
    if (fault >= 0) stuck[fault] = ~src_byte(fault, s);
    seed = s; src_base = f; idx = 0; stall = 0; pulses = 0; vpp_rises = 0;
    first_addr = AW'(f); last_addr = AW'(l); src_on = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(error == 1'b0, "R10 start clears error", error, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      first_addr = '0; last_addr = AW'(NLOC - 1); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int c = 0; c < 3000 && !got_done; c++) begin
      if (done) got_done = 1; else @(negedge clk);
    end
    chk(got_done, "R11 run finishes", got_done, 1);
    src_on = 0;
    stop = (fault >= 0 && fault <= l) ? fault : l;
    for (int a = f; a <= stop; a++) begin
      exp_taken++;
      if (src_byte(a, s) != 8'hFF) exp_pulses++;
    end
    chk(pulses == exp_pulses, "R8 pulse count", pulses, exp_pulses);
    chk(idx == exp_taken, "R7 bytes taken", idx, exp_taken);
    chk(vpp_rises == ((f <= l) ? 1 : 0), "R1 supply raised", vpp_rises, (f <= l) ? 1 : 0);
    for (int a = 0; a < NLOC; a++) begin
      logic [7:0] e;
      e = (a >= f && a <= stop) ? src_byte(a, s) : 8'hFF;
      chk(mem[a] == e, "R7 cell contents", mem[a], e);
    end
    if (fault >= 0 && fault >= f && fault <= l) begin
      chk(error && err_addr == AW'(fault), "R10 error address", err_addr, fault);
      repeat (4) @(negedge clk);
      chk(error && err_addr == AW'(fault), "R10 error holds", error, 1);
    end else begin
      chk(!error, "R10 no error", error, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!vpp_en && oe_n && !addr_oe && !dq_oe && !prog_pulse && !byte_ready,
        "R12 reset controls", {vpp_en, oe_n, addr_oe, dq_oe}, 4'b0100);
    chk(!done && !error && !busy, "R12 reset status", {done, error, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, NLOC - 1, 0, -1, 0);   // full range
    run(3, 9, 1, -1, 1);          // partial, with ignored start mid-run (R1)
    run(7, 7, 2, -1, 0);          // single location
    run(8, 8, 2, -1, 0);          // single FF location (R8)
    run(9, 3, 0, -1, 0);          // empty range (R1)
    run(2, 12, 3, 6, 0);          // readback fault (R10)
    run(NLOC - 1, NLOC - 1, 4, -1, 0); // top address
    run(10, 14, 5, 12, 0);        // fault near end; also clears previous error
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule